// File: doc/BRIEF.md
# Pixel Pipeline Sync Status Unit

This block sits beside the configuration-register loader of a pixel pipeline and turns selected register writes into pipeline status. A draw-done write carrying the finish code raises a finish event. Two token addresses both capture a 16-bit synchronization token, and only one of them also raises a token event. Two bounding-box writes each load a pair of 10-bit extents. A write to the counter-clear address zeroes a bank of performance counters. The counters themselves are advanced by external increment strobes.

A CPU-side register port reads the status and writes the interrupt controls. Each event source has an enable bit and a sticky status bit that is cleared by writing one to it. The interrupt output is a registered OR of every status bit that is both set and enabled. Loader addresses are parameters. The finish code and the CPU register index map are fixed by the package.

Top module: `pe_sync_status`

## Requirements
- R1: After reset the enables, status bits, token, bounding-box entries, performance counters, `irq` and `cpu_rdata` are all zero.
- R2: A loader write to the draw-done address whose payload bits [7:0] equal 0x02 sets the finish status bit (control bit 3), whatever the upper payload bits are. Any other low byte leaves it unchanged.
- R3: A loader write to the plain token address loads payload bits [15:0] into the token register (CPU index 1) and leaves the token status bit (control bit 2) unchanged.
- R4: A loader write to the interrupting token address loads payload bits [15:0] into the token register and sets the token status bit.
- R5: A write to the first box address sets entry 0 (index 2) to payload[19:10] and entry 1 (index 3) to payload[9:0]. A write to the second box address does the same for entries 2 and 3 (indices 4 and 5). The other pair is unchanged.
- R6: A loader write to the counter-clear address zeroes every performance counter, whatever the payload. A clear takes priority over an increment in the same cycle.
- R7: Each performance counter (indices 6 to 9) increases by one on every clock edge at which its `perf_inc` bit is high.
- R8: A CPU write to index 0 loads the enables from bits [1:0] (bit 0 token, bit 1 finish). The same write clears each status bit whose position in bits [3:2] is written as one, and leaves the others unchanged. A status set in the same cycle wins over the clear.
- R9: `irq` goes high one cycle after some status bit and its enable are both set. It stays low while those status bits are masked.
- R10: A CPU read strobe returns the addressed register on `cpu_rdata` after the next clock edge. Index 0 reads enables in bits [1:0] and status in bits [3:2]. Indices outside 0 to 9 read zero. `cpu_rdata` holds between reads.
- R11: Loader writes to any other address change no token, status or bounding-box state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loader register-write strobe |
| cfg_addr | input | CFG_AW | Loader register address |
| cfg_data | input | CFG_DW | Loader register payload |
| perf_inc | input | NUM_PERF | Per-counter increment strobes |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_rd_en | input | 1 | CPU register read strobe |
| cpu_addr | input | CPU_AW | CPU register index |
| cpu_wdata | input | CPU_DW | CPU write data |
| cpu_rdata | output | CPU_DW | Registered CPU read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A loader write, CPU write or increment strobe takes effect at the clock edge where it is sampled. `irq` follows one edge later, because it is registered from the status and enable bits. A read returns data one edge after its strobe. The bench drives every stimulus on falling edges and reads state back through the CPU port, so each value is observed at least one full edge after it was due. Each interrupt check samples `irq` at both falling edges around its due edge. This confirms the level before the edge and the level after it.

// File: rtl/pe_sync_pkg.sv
package pe_sync_pkg;

  // Interrupt sources, in control-register bit order
  localparam int NUM_SRC    = 2;
  localparam int SRC_TOKEN  = 0;
  localparam int SRC_FINISH = 1;

  // Bounding-box entries: two loader writes, two entries each
  localparam int NUM_BBOX   = 4;
  localparam int BBOX_PAIRS = NUM_BBOX / 2;

  // CPU register index map
  localparam int IDX_CTRL   = 0;
  localparam int IDX_TOKEN  = 1;
  localparam int IDX_BBOX0  = 2;
  localparam int IDX_PERF0  = IDX_BBOX0 + NUM_BBOX;

  // Control register layout
  localparam int CTRL_EN_LSB = 0;
  localparam int CTRL_ST_LSB = CTRL_EN_LSB + NUM_SRC;

  localparam logic [7:0] FINISH_CODE = 8'h02;

  typedef struct packed {
    logic                  finish_set;
    logic                  token_load;
    logic                  token_irq;
    logic [BBOX_PAIRS-1:0] bbox_load;
    logic                  perf_clear;
  } cfg_evt_t;

endpackage

// File: rtl/pe_cfg_decode.sv
module pe_cfg_decode
  import pe_sync_pkg::*;
#(
  parameter int CFG_AW        = 8,
  parameter int CFG_DW        = 24,
  parameter int ADDR_DRAWDONE = 'h45,
  parameter int ADDR_TOKEN    = 'h47,
  parameter int ADDR_TOKEN_IRQ= 'h48,
  parameter int ADDR_BBOX_A   = 'h55,
  parameter int ADDR_BBOX_B   = 'h56,
  parameter int ADDR_PERF_CLR = 'h67
) (
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  output cfg_evt_t          evt
);

  logic hit_dd, hit_tok, hit_toki, hit_bba, hit_bbb, hit_clr;

  always_comb begin
    hit_dd   = cfg_we && (cfg_addr == CFG_AW'(ADDR_DRAWDONE));
    hit_tok  = cfg_we && (cfg_addr == CFG_AW'(ADDR_TOKEN));
    hit_toki = cfg_we && (cfg_addr == CFG_AW'(ADDR_TOKEN_IRQ));
    hit_bba  = cfg_we && (cfg_addr == CFG_AW'(ADDR_BBOX_A));
    hit_bbb  = cfg_we && (cfg_addr == CFG_AW'(ADDR_BBOX_B));
    hit_clr  = cfg_we && (cfg_addr == CFG_AW'(ADDR_PERF_CLR));
  end

  always_comb begin
    evt              = '0;
    evt.finish_set   = hit_dd && (cfg_data[7:0] == FINISH_CODE);
    evt.token_load   = hit_tok || hit_toki;
    evt.token_irq    = hit_toki;
    evt.bbox_load[0] = hit_bba;
    evt.bbox_load[1] = hit_bbb;
    evt.perf_clear   = hit_clr;
  end

endmodule

// File: rtl/pe_irq_ctrl.sv
module pe_irq_ctrl #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               ctrl_wr_i,
  input  logic [NUM_SRC-1:0] en_data_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] stat_o,
  output logic               irq_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        stat_o[g] <= 1'b0;
        en_o[g]   <= 1'b0;
      end else begin
        if (set_i[g])
          stat_o[g] <= 1'b1;              // set wins over clear
        else if (ctrl_wr_i && clr_mask_i[g])
          stat_o[g] <= 1'b0;
        if (ctrl_wr_i)
          en_o[g] <= en_data_i[g];
      end
    end

    // R8: a set event is visible as status on the next cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> stat_o[g]);

    // R8: clear without a concurrent set drops the status bit
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr_i && clr_mask_i[g] && !set_i[g]) |=> !stat_o[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat_o & en_o);
  end

  // R9: no enable means no interrupt on the following cycle
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (en_o == '0) |=> !irq_o);

endmodule

// File: rtl/pe_perf_bank.sv
module pe_perf_bank #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CNT-1:0]            inc_i,
  input  logic                          clear_i,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cnt_o
);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || clear_i)
        cnt_o[g] <= '0;                   // clear beats increment
      else if (inc_i[g])
        cnt_o[g] <= cnt_o[g] + CNT_W'(1);
    end

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      clear_i |=> (cnt_o[g] == '0));

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
      (!clear_i && inc_i[g]) |=> (cnt_o[g] == $past(cnt_o[g]) + CNT_W'(1)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!clear_i && !inc_i[g]) |=> $stable(cnt_o[g]));
  end

endmodule

// File: rtl/pe_sync_status.sv
module pe_sync_status
  import pe_sync_pkg::*;
#(
  parameter int CFG_AW         = 8,
  parameter int CFG_DW         = 24,
  parameter int TOKEN_W        = 16,
  parameter int BBOX_W         = 10,
  parameter int NUM_PERF       = 4,
  parameter int PERF_W         = 32,
  parameter int CPU_AW         = 4,
  parameter int CPU_DW         = 32,
  parameter int ADDR_DRAWDONE  = 'h45,
  parameter int ADDR_TOKEN     = 'h47,
  parameter int ADDR_TOKEN_IRQ = 'h48,
  parameter int ADDR_BBOX_A    = 'h55,
  parameter int ADDR_BBOX_B    = 'h56,
  parameter int ADDR_PERF_CLR  = 'h67
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0]   cfg_data,
  input  logic [NUM_PERF-1:0] perf_inc,
  input  logic                cpu_wr_en,
  input  logic                cpu_rd_en,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [CPU_DW-1:0]   cpu_wdata,
  output logic [CPU_DW-1:0]   cpu_rdata,
  output logic                irq
);

  localparam int NUM_REGS = IDX_PERF0 + NUM_PERF;

  cfg_evt_t                              evt;
  logic [NUM_SRC-1:0]                    irq_set, irq_en, irq_stat;
  logic                                  ctrl_wr;
  logic [TOKEN_W-1:0]                    token_q;
  logic [NUM_BBOX-1:0][BBOX_W-1:0]       bbox_q;
  logic [NUM_PERF-1:0][PERF_W-1:0]       perf_cnt;
  logic [CPU_DW-1:0]                     rd_word;

  pe_cfg_decode #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW),
    .ADDR_DRAWDONE(ADDR_DRAWDONE), .ADDR_TOKEN(ADDR_TOKEN),
    .ADDR_TOKEN_IRQ(ADDR_TOKEN_IRQ), .ADDR_BBOX_A(ADDR_BBOX_A),
    .ADDR_BBOX_B(ADDR_BBOX_B), .ADDR_PERF_CLR(ADDR_PERF_CLR)
  ) u_decode (
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .evt(evt)
  );

  always_comb begin
    irq_set             = '0;
    irq_set[SRC_TOKEN]  = evt.token_irq;
    irq_set[SRC_FINISH] = evt.finish_set;
    ctrl_wr             = cpu_wr_en && (cpu_addr == CPU_AW'(IDX_CTRL));
  end

  pe_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst),
    .set_i(irq_set),
    .ctrl_wr_i(ctrl_wr),
    .en_data_i(cpu_wdata[CTRL_EN_LSB +: NUM_SRC]),
    .clr_mask_i(cpu_wdata[CTRL_ST_LSB +: NUM_SRC]),
    .en_o(irq_en), .stat_o(irq_stat), .irq_o(irq)
  );

  pe_perf_bank #(.NUM_CNT(NUM_PERF), .CNT_W(PERF_W)) u_perf (
    .clk(clk), .rst(rst), .inc_i(perf_inc),
    .clear_i(evt.perf_clear), .cnt_o(perf_cnt)
  );

  // Synchronization token
  always_ff @(posedge clk) begin
    if (rst)                 token_q <= '0;
    else if (evt.token_load) token_q <= cfg_data[TOKEN_W-1:0];
  end

  // Bounding-box entries: even entry takes the upper field, odd the lower
  for (genvar g = 0; g < NUM_BBOX; g++) begin : g_bbox
    logic [BBOX_W-1:0] field;
    if (g % 2 == 0) begin : g_upper
      assign field = cfg_data[2*BBOX_W-1:BBOX_W];
    end else begin : g_lower
      assign field = cfg_data[BBOX_W-1:0];
    end
    always_ff @(posedge clk) begin
      if (rst)                      bbox_q[g] <= '0;
      else if (evt.bbox_load[g/2])  bbox_q[g] <= field;
    end
  end

  // CPU read path
  always_comb begin
    rd_word = '0;
    if (cpu_addr == CPU_AW'(IDX_CTRL)) begin
      rd_word[CTRL_EN_LSB +: NUM_SRC] = irq_en;
      rd_word[CTRL_ST_LSB +: NUM_SRC] = irq_stat;
    end
    if (cpu_addr == CPU_AW'(IDX_TOKEN))
      rd_word[TOKEN_W-1:0] = token_q;
    for (int i = 0; i < NUM_BBOX; i++)
      if (cpu_addr == CPU_AW'(IDX_BBOX0 + i))
        rd_word[BBOX_W-1:0] = bbox_q[i];
    for (int i = 0; i < NUM_PERF; i++)
      if (cpu_addr == CPU_AW'(IDX_PERF0 + i))
        rd_word[PERF_W-1:0] = perf_cnt[i];
  end

  always_ff @(posedge clk) begin
    if (rst)            cpu_rdata <= '0;
    else if (cpu_rd_en) cpu_rdata <= rd_word;
  end

  // R3: the token only moves on a token write
  p_token_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !evt.token_load |=> $stable(token_q));

  // R4: a token write captures the low payload bits
  p_token_load_r4: assert property (@(posedge clk) disable iff (rst)
    evt.token_load |=> (token_q == $past(cfg_data[TOKEN_W-1:0])));

  // R11: box entries only move on a box write
  p_bbox_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (evt.bbox_load == '0) |=> $stable(bbox_q));

  // R10: read data holds without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd_en |=> $stable(cpu_rdata));

  initial begin
    assert (NUM_REGS <= (1 << CPU_AW))
      else $error("register map exceeds CPU index range");
  end

endmodule

// File: tb/pe_sync_status_tb.sv
module pe_sync_status_tb;

  localparam int A_DD   = 'h45;
  localparam int A_TOK  = 'h47;
  localparam int A_TOKI = 'h48;
  localparam int A_BBA  = 'h55;
  localparam int A_BBB  = 'h56;
  localparam int A_CLR  = 'h67;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [23:0] cfg_data = '0;
  logic [3:0]  perf_inc = '0;
  logic        cpu_wr_en = 1'b0;
  logic        cpu_rd_en = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pe_sync_status u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .perf_inc(perf_inc), .cpu_wr_en(cpu_wr_en),
    .cpu_rd_en(cpu_rd_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input int a, input logic [23:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'(a); cfg_data = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cpu_wr(input int idx, input logic [31:0] d);
    @(negedge clk); cpu_wr_en = 1'b1; cpu_addr = 4'(idx); cpu_wdata = d;
    @(negedge clk); cpu_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
    @(negedge clk); cpu_rd_en = 1'b1; cpu_addr = 4'(idx);
    @(negedge clk); cpu_rd_en = 1'b0;
    check(req, cpu_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 irq", 32'(irq), 0);
    check("R1 rdata", cpu_rdata, 0);
    rd_chk("R1 ctrl", 0, 0);
    rd_chk("R1 token", 1, 0);
    rd_chk("R1 bbox0", 2, 0);
    rd_chk("R1 perf3", 9, 0);
  endtask

  task automatic t_other_addr;
    cpu_wr(0, 32'h3);
    rd_chk("R8 enables", 0, 32'h3);
    cfg_wr('h10, 24'hFFFFFF);
    cfg_wr('h46, 24'h000002);
    rd_chk("R11 token", 1, 0);
    rd_chk("R11 ctrl", 0, 32'h3);
    rd_chk("R11 bbox1", 3, 0);
  endtask

  task automatic t_finish;
    cfg_wr(A_DD, 24'h000001);
    rd_chk("R2 other code", 0, 32'h3);
    check("R2 no irq", 32'(irq), 0);
    cfg_wr(A_DD, 24'h00AB02);
    check("R9 irq not before edge", 32'(irq), 0);
    @(negedge clk);
    check("R9 irq after finish", 32'(irq), 1);
    rd_chk("R2 finish set", 0, 32'hB);
    cpu_wr(0, 32'h3);
    rd_chk("R8 write zero keeps", 0, 32'hB);
    cpu_wr(0, 32'hB);
    @(negedge clk);
    check("R9 irq drops", 32'(irq), 0);
    rd_chk("R8 w1c finish", 0, 32'h3);
  endtask

  task automatic t_tokens;
    cfg_wr(A_TOK, 24'h12ABCD);
    rd_chk("R3 token value", 1, 32'hABCD);
    rd_chk("R3 no status", 0, 32'h3);
    check("R3 no irq", 32'(irq), 0);
    cfg_wr(A_TOKI, 24'hFF5678);
    @(negedge clk);
    check("R4 irq", 32'(irq), 1);
    rd_chk("R4 token value", 1, 32'h5678);
    rd_chk("R4 status", 0, 32'h7);
    cpu_wr(0, 32'h4);
    rd_chk("R8 disable and clear", 0, 32'h0);
    cfg_wr(A_TOKI, 24'h000001);
    @(negedge clk); @(negedge clk);
    check("R9 masked", 32'(irq), 0);
    rd_chk("R4 masked status", 0, 32'h4);
    cpu_wr(0, 32'h1);
    @(negedge clk);
    check("R9 unmask", 32'(irq), 1);
    cpu_wr(0, 32'h5);
    rd_chk("R8 clear token", 0, 32'h1);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(A_TOKI); cfg_data = 24'h0000AA;
    cpu_wr_en = 1'b1; cpu_addr = 4'd0; cpu_wdata = 32'h5;
    @(negedge clk);
    cfg_we = 1'b0; cpu_wr_en = 1'b0;
    rd_chk("R8 set wins", 0, 32'h5);
    cpu_wr(0, 32'h4);
    rd_chk("R8 cleared", 0, 32'h0);
  endtask

  task automatic t_bbox;
    cfg_wr(A_BBA, 24'hFAAD55);
    rd_chk("R5 entry0", 2, 32'h2AB);
    rd_chk("R5 entry1", 3, 32'h155);
    rd_chk("R5 entry2 untouched", 4, 0);
    cfg_wr(A_BBB, 24'h0FFC01);
    rd_chk("R5 entry2", 4, 32'h3FF);
    rd_chk("R5 entry3", 5, 32'h001);
    rd_chk("R5 entry0 kept", 2, 32'h2AB);
  endtask

  task automatic pulse_inc(input logic [3:0] m, input int n);
    @(negedge clk); perf_inc = m;
    repeat (n) @(negedge clk);
    perf_inc = '0;
  endtask

  task automatic t_perf;
    pulse_inc(4'b0101, 5);
    pulse_inc(4'b0010, 3);
    rd_chk("R7 perf0", 6, 5);
    rd_chk("R7 perf1", 7, 3);
    rd_chk("R7 perf2", 8, 5);
    rd_chk("R7 perf3", 9, 0);
    cfg_wr(A_CLR, 24'h123456);
    rd_chk("R6 perf0 cleared", 6, 0);
    rd_chk("R6 perf2 cleared", 8, 0);
    pulse_inc(4'b1111, 2);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(A_CLR); cfg_data = 24'h0; perf_inc = 4'hF;
    @(negedge clk);
    cfg_we = 1'b0; perf_inc = '0;
    rd_chk("R6 clear beats inc", 7, 0);
    pulse_inc(4'b1000, 1);
    rd_chk("R7 after clear", 9, 1);
    rd_chk("R10 unmapped", 15, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_other_addr;
    t_finish;
    t_tokens;
    t_set_wins;
    t_bbox;
    t_perf;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule